// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block keeps the interrupt status of every channel in a multi-channel DMA engine. It also folds that status into one summary word and one interrupt line. Each channel has three sticky causes: a bus error, a finished transfer and a loaded descriptor. It also has one live cause, which is active while the channel sits halted and its halt-interrupt enable is set. The DMA datapath pulses the event inputs and drives the per-transfer enables and the halted level.

Software sees one status word per channel and one read-only summary word. To find out why the interrupt line is high, it reads a channel word. It then writes that same value back. Every sticky cause that was shown is cleared, and the halt enable keeps its value because the write carries it back.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every channel word reads 0, the summary word reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on `ev_err_i[c]` sets bit 0 of channel word c, with no enable involved.
- R3: A pulse on `ev_end_i[c]` sets bit 1 of channel word c only if `end_ie_i[c]` is high in the same cycle. Otherwise the word is unchanged.
- R4: A pulse on `ev_start_i[c]` sets bit 2 of channel word c only if `start_ie_i[c]` is high in the same cycle. Otherwise the word is unchanged.
- R5: Bit 3 of a channel word is the halt-interrupt enable, which software reads and writes. Bit 4 is read-only and shows `halted_i[c]`. While bit 3 and `halted_i[c]` are both high, channel c is pending. It stops being pending as soon as either of them drops, and no write clears this cause.
- R6: A write to channel word c clears each of bits 0..2 for which the written bit is 1. A flag whose written bit is 0 is left unchanged. Writing back the value just read clears every sticky cause it showed.
- R7: If an event pulse and a clearing write for the same flag fall in the same cycle, the flag ends up set.
- R8: Channel words sit at word addresses 0..15 and the summary word at address 16. Channel-word bits 31:5 and summary bits 31:16 read as 0. Writes to those bits, and any write to the summary word, have no effect.
- R9: `irq_o` is high exactly when the summary word is non-zero.
- R10: Summary bit c is the OR of channel c's three sticky flags and its active halt cause. A write to one channel never changes another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 5 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| ev_err_i | input | 16 | Per-channel bus-error pulse |
| ev_end_i | input | 16 | Per-channel transfer-done pulse |
| end_ie_i | input | 16 | Per-channel enable for the transfer-done cause |
| ev_start_i | input | 16 | Per-channel descriptor-loaded pulse |
| start_ie_i | input | 16 | Per-channel enable for the descriptor-loaded cause |
| halted_i | input | 16 | Per-channel halted (idle or stopped) level |
| irq_o | output | 1 | Global interrupt, high while any channel is pending |

## Verification
The timing of each result is fixed:
- An event pulse or a write seen at a rising edge shows up in the read data and on `irq_o` right after that edge.
- A change on `halted_i` or on `addr_i` passes through combinationally.

The bench drives every input on the falling edge. Its scoreboard has one rule: each read driven on a falling edge is compared one nanosecond after the next rising edge. So every sticky update has landed before the compare, and no input changes while the sample is taken. Expected words are built from the bit layout in the requirements, one set of values per stimulus.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DW      = 32;
  localparam int CW      = 5;   // live bits in a channel word
  localparam int B_ERR   = 0;
  localparam int B_END   = 1;
  localparam int B_START = 2;
  localparam int B_HEN   = 3;
  localparam int B_HALT  = 4;
  localparam int NCLR    = 3;   // write-one-to-clear flags in bits NCLR-1:0
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_sel_i,
  input  logic [CW-2:0] wdata_i,
  input  logic          ev_err_i,
  input  logic          ev_end_i,
  input  logic          end_ie_i,
  input  logic          ev_start_i,
  input  logic          start_ie_i,
  input  logic          halted_i,
  output logic [CW-1:0] word_o,
  output logic          pend_o
);
  logic err_q, end_q, start_q, hen_q;
  logic err_d, end_d, start_d, hen_d;
  logic set_err, set_end, set_start;
  logic upd_en;

  assign set_err   = ev_err_i;
  assign set_end   = ev_end_i & end_ie_i;
  assign set_start = ev_start_i & start_ie_i;
  assign upd_en    = wr_sel_i | set_err | set_end | set_start;

  // next state: a clear is applied first, then a set overrides it
  always_comb begin
    err_d   = err_q;
    end_d   = end_q;
    start_d = start_q;
    hen_d   = hen_q;
    if (wr_sel_i) begin
      if (wdata_i[B_ERR])   err_d   = 1'b0;
      if (wdata_i[B_END])   end_d   = 1'b0;
      if (wdata_i[B_START]) start_d = 1'b0;
      hen_d = wdata_i[B_HEN];
    end
    if (set_err)   err_d   = 1'b1;
    if (set_end)   end_d   = 1'b1;
    if (set_start) start_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      end_q   <= 1'b0;
      start_q <= 1'b0;
      hen_q   <= 1'b0;
    end else if (upd_en) begin
      err_q   <= err_d;
      end_q   <= end_d;
      start_q <= start_d;
      hen_q   <= hen_d;
    end
  end

  always_comb begin
    word_o         = '0;
    word_o[B_ERR]  = err_q;
    word_o[B_END]  = end_q;
    word_o[B_START]= start_q;
    word_o[B_HEN]  = hen_q;
    word_o[B_HALT] = halted_i;
  end

  assign pend_o = err_q | end_q | start_q | (hen_q & halted_i);

  p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_err_i |=> word_o[B_ERR]);
  p_end_gate_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_end_i && !end_ie_i && !wr_sel_i) |=> $stable(word_o[B_END]));
  p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_start_i && !start_ie_i && !wr_sel_i) |=> $stable(word_o[B_START]));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_sel_i && wdata_i[B_ERR] && !ev_err_i) |=> !word_o[B_ERR]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_sel_i && wdata_i[B_END] && ev_end_i && end_ie_i) |=> word_o[B_END]);
  p_halt_live_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (word_o[B_HEN] && halted_i) |-> pend_o);
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int AW       = 5,
  parameter int SUM_ADDR = 16
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [NCH-1:0][CW-1:0]   chan_word_i,
  input  logic [NCH-1:0]           sum_i,
  input  logic                     irq_i,
  output logic [NCH-1:0]           wr_sel_o,
  output logic [DW-1:0]            rdata_o
);
  localparam logic [AW-1:0] SUM_A = AW'(SUM_ADDR);

  logic [NCH-1:0] hit;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign hit[c]      = (addr_i == AW'(c));
    assign wr_sel_o[c] = wr_en_i & hit[c];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == SUM_A) begin
      rdata_o[NCH-1:0] = sum_i;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (hit[c]) rdata_o[CW-1:0] = chan_word_i[c];
      end
    end
  end

  p_wsel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
  p_sum_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr_i == SUM_A) |-> (rdata_o[DW-1:NCH] == '0));
  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr_i == SUM_A) |-> ((rdata_o != '0) == irq_i));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int AW       = 5,
  parameter int SUM_ADDR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NCH-1:0]   ev_err_i,
  input  logic [NCH-1:0]   ev_end_i,
  input  logic [NCH-1:0]   end_ie_i,
  input  logic [NCH-1:0]   ev_start_i,
  input  logic [NCH-1:0]   start_ie_i,
  input  logic [NCH-1:0]   halted_i,
  output logic             irq_o
);
  logic                   rst_sync_n;
  logic [NCH-1:0]         wr_sel;
  logic [NCH-1:0][CW-1:0] chan_word;
  logic [NCH-1:0]         sum;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:CW-1];

  dma_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_irq_chan u_ch (
      .clk        (clk),
      .rst_ni     (rst_sync_n),
      .wr_sel_i   (wr_sel[c]),
      .wdata_i    (wdata_i[CW-2:0]),
      .ev_err_i   (ev_err_i[c]),
      .ev_end_i   (ev_end_i[c]),
      .end_ie_i   (end_ie_i[c]),
      .ev_start_i (ev_start_i[c]),
      .start_ie_i (start_ie_i[c]),
      .halted_i   (halted_i[c]),
      .word_o     (chan_word[c]),
      .pend_o     (sum[c])
    );
  end

  assign irq_o = |sum;

  dma_irq_regif #(
    .NCH      (NCH),
    .AW       (AW),
    .SUM_ADDR (SUM_ADDR)
  ) u_regif (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .chan_word_i (chan_word),
    .sum_i       (sum),
    .irq_i       (irq_o),
    .wr_sel_o    (wr_sel),
    .rdata_o     (rdata_o)
  );

  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |=> (rst_sync_n || !irq_o));
endmodule

// File: tb/tb_dma_irq_agg.sv
`timescale 1ns/1ps
module tb_dma_irq_agg;
  localparam int NCH = 16;
  localparam int SUM = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [4:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [15:0] ev_err_i, ev_end_i, end_ie_i, ev_start_i, start_ie_i, halted_i;
  logic        irq_o;

  always #2 clk = ~clk;

  dma_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ev_err_i(ev_err_i),
    .ev_end_i(ev_end_i), .end_ie_i(end_ie_i), .ev_start_i(ev_start_i),
    .start_ie_i(start_ie_i), .halted_i(halted_i), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] data;
    logic        irq;
    int          req;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // monitor: compares each queued read one ns after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (rdata_o !== e.data || irq_o !== e.irq) begin
          n_fail++;
          $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                   e.req, rdata_o, irq_o, e.data, e.irq);
        end
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] d, input logic i, input int r);
    exp_t e;
    @(negedge clk);
    addr_i = 5'(a);
    e.data = d; e.irq = i; e.req = r;
    q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr_i = 5'(a); wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input int kind, input int ch, input logic ie);
    @(negedge clk);
    case (kind)
      0: ev_err_i[ch] = 1'b1;
      1: begin ev_end_i[ch] = 1'b1; end_ie_i[ch] = ie; end
      default: begin ev_start_i[ch] = 1'b1; start_ie_i[ch] = ie; end
    endcase
    @(negedge clk);
    ev_err_i = '0; ev_end_i = '0; ev_start_i = '0; end_ie_i = '0; start_ie_i = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    ev_err_i = '0; ev_end_i = '0; end_ie_i = '0; ev_start_i = '0;
    start_ie_i = '0; halted_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 32'h0, 1'b0, 1);
    rd(15, 32'h0, 1'b0, 1);
    rd(SUM, 32'h0, 1'b0, 1);

    // R2 error always latches; R10 summary bit; R9 irq
    pulse(0, 3, 1'b0);
    rd(3, 32'h1, 1'b1, 2);
    rd(SUM, 32'h8, 1'b1, 10);
    // R6 write-back clears
    wr(3, 32'h1);
    rd(3, 32'h0, 1'b0, 6);
    rd(SUM, 32'h0, 1'b0, 9);

    // R3 end gated by enable
    pulse(1, 5, 1'b0);
    rd(5, 32'h0, 1'b0, 3);
    pulse(1, 5, 1'b1);
    rd(5, 32'h2, 1'b1, 3);
    // R4 start gated by enable
    pulse(2, 7, 1'b0);
    rd(7, 32'h0, 1'b1, 4);
    pulse(2, 7, 1'b1);
    rd(7, 32'h4, 1'b1, 4);

    // R6 writing zero keeps flags
    wr(5, 32'h0);
    rd(5, 32'h2, 1'b1, 6);
    // R8 reserved bits ignored, summary writes ignored
    wr(5, 32'hFFFF_FFE0);
    rd(5, 32'h2, 1'b1, 8);
    wr(SUM, 32'hFFFF_FFFF);
    rd(SUM, 32'h0000_00A0, 1'b1, 8);
    // R10 clearing one channel leaves the other
    wr(7, 32'h4);
    rd(SUM, 32'h0000_0020, 1'b1, 10);
    rd(5, 32'h2, 1'b1, 10);
    wr(5, 32'h2);
    rd(SUM, 32'h0, 1'b0, 6);

    // R5 halt cause is a live level
    wr(9, 32'h8);
    rd(9, 32'h8, 1'b0, 5);
    @(negedge clk); halted_i[9] = 1'b1;
    rd(9, 32'h18, 1'b1, 5);
    rd(SUM, 32'h200, 1'b1, 5);
    wr(9, 32'h18);
    rd(SUM, 32'h200, 1'b1, 5);
    @(negedge clk); halted_i[9] = 1'b0;
    rd(SUM, 32'h0, 1'b0, 5);
    wr(9, 32'h0);
    @(negedge clk); halted_i[9] = 1'b1;
    rd(9, 32'h10, 1'b0, 5);
    @(negedge clk); halted_i[9] = 1'b0;

    // R7 set wins over same-cycle clear
    @(negedge clk);
    addr_i = 5'd0; wdata_i = 32'h1; wr_en_i = 1'b1; ev_err_i[0] = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; ev_err_i = '0;
    rd(0, 32'h1, 1'b1, 7);

    // R9/R10 two channels pending, clear one
    pulse(0, 15, 1'b0);
    rd(SUM, 32'h8001, 1'b1, 9);
    wr(15, 32'h7);
    rd(SUM, 32'h0001, 1'b1, 10);
    wr(0, 32'h1);
    rd(SUM, 32'h0, 1'b0, 9);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule